// File: doc/BRIEF.md
# Block-Structured Address Sequencer

This block produces a stream of 24-bit addresses, one per clock, grouped into a programmable number of equal-length blocks. Four configuration registers set the base address, the step, the addresses per block and the number of blocks. A sequence starts from an active-low start pulse on `start_n`, or from a software start command given through the write port. A software start is echoed on `start_out_n`, so that peer sequencers whose `start_n` pins are wired to it begin on the same clock as this unit.

Active-low strobes mark three points in the sequence: the first address, the last address of every block, and the final address. The `hold` input freezes generation only where one block ends and the next would begin. After reset, a fixed busy window blocks all writes and software starts.

Top module: `blkaddr_gen`

## Requirements
- R1: `busy_n` is high during reset. It is low from the first clock edge after reset is released, for exactly 25 clocks, and stays high after that.
- R2: A register write or software start sampled while `busy_n` is low has no effect, and `start_out_n` stays high.
- R3: The register select codes are: 0 for base address, 1 for step, 2 for addresses per block, and 3 for block count. Block length and block count take the low 16 bits of `wr_data`, and a written 0 acts as 1. After reset the registers hold base 0, step 1, length 1 and count 1.
- R4: If `start_n` is sampled low at clock edge E while the block is idle, the base address appears on `addr` after edge E+1, and `first_n` is low for that one cycle only.
- R5: Each following address is the previous address plus the step, modulo 2^24. This holds across block boundaries as well as within a block.
- R6: `blk_end_n` is low exactly while the last address of a block is on `addr`.
- R7: `seq_end_n` is low exactly while the last address of the sequence is on `addr`. After that, `addr` holds its value and all strobes stay high until the next start.
- R8: If `go` is sampled with `busy_n` high and the block idle, `start_out_n` is low for the single following cycle, and the base address appears two edges after the `go` edge. A start through `start_n` never drives `start_out_n` low.
- R9: If `hold` is sampled high while a block's last address is shown and it is not the sequence's last, `addr` freezes and the strobes go high. The next block's first address appears at the first edge that samples `hold` low. `hold` has no effect inside a block.
- R10: A `start_n` pulse or a `go` that arrives while a sequence runs is ignored, and the sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low one-clock start pulse |
| hold | input | 1 | Pause request, honoured at block boundaries |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | 24 | Register write data |
| go | input | 1 | Software start command |
| addr | output | 24 | Address output |
| first_n | output | 1 | Active-low first-address strobe |
| blk_end_n | output | 1 | Active-low block-end strobe |
| seq_end_n | output | 1 | Active-low sequence-end strobe |
| start_out_n | output | 1 | Active-low echo of a software start |
| busy_n | output | 1 | Active-low post-reset busy window |

## Verification
The bench builds the block with its defaults: 24-bit addresses, 16-bit block counters and a 25-clock busy window. Because block length and block count are run-time registers, short sequences of one to four addresses per block reach every strobe coincidence and both hold positions in a few cycles. The full address width lets a base near the top of the space show the modulo wrap. Counting the busy window directly makes its exact length and its one-clock entry delay observable at the port.

// File: rtl/blkaddr_pkg.sv
package blkaddr_pkg;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_STEP = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_PAUSE = 2'd2
  } seq_st_e;

endpackage

// File: rtl/blkaddr_busy.sv
module blkaddr_busy #(
  parameter int BUSY_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  output logic busy_n,
  output logic wr_ok
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUSY_CYCLES);

  logic [CW-1:0] cnt;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      busy_q <= 1'b1;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      busy_q <= (cnt == LAST);
    end
  end

  assign busy_n = busy_q;
  assign wr_ok  = busy_q && (cnt == LAST);

  AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> !busy_n); // R1
  AST_BUSY_STAYS_OFF: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> busy_n); // R1

endmodule

// File: rtl/blkaddr_regs.sv
module blkaddr_regs
  import blkaddr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_ok,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] step,
  output logic [CNT_W-1:0]  blen,
  output logic [CNT_W-1:0]  bcnt
);
  logic [CNT_W-1:0] cnt_field;
  logic [CNT_W-1:0] cnt_clamped;

  assign cnt_field   = wr_data[CNT_W-1:0];
  assign cnt_clamped = (cnt_field == '0) ? CNT_W'(1) : cnt_field;

  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      step <= ADDR_W'(1);
      blen <= CNT_W'(1);
      bcnt <= CNT_W'(1);
    end else if (wr_en && wr_ok) begin
      case (reg_sel_e'(wr_sel))
        SEL_BASE: base <= wr_data;
        SEL_STEP: step <= wr_data;
        SEL_LEN:  blen <= cnt_clamped;
        SEL_CNT:  bcnt <= cnt_clamped;
        default:  ;
      endcase
    end
  end

  AST_WR_GATED: assert property (@(posedge clk) disable iff (rst)
    !wr_ok |=> ($stable(base) && $stable(step) && $stable(blen) && $stable(bcnt))); // R2
  AST_COUNTS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ok && wr_sel[1]) |=> (blen != '0 && bcnt != '0)); // R3

endmodule

// File: rtl/blkaddr_trig.sv
module blkaddr_trig (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  input  logic go,
  input  logic wr_ok,
  input  logic idle,
  output logic start_out_n,
  output logic launch
);
  logic so_q;
  logic armed;
  logic trig;

  assign trig   = !start_n || !so_q;
  assign launch = armed && !trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      so_q  <= 1'b1;
      armed <= 1'b0;
    end else begin
      so_q <= !(go && wr_ok && idle && so_q && !armed);
      if (!armed && trig && idle) armed <= 1'b1;
      else if (armed && !trig)    armed <= 1'b0;
    end
  end

  assign start_out_n = so_q;

  AST_ECHO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !start_out_n |=> start_out_n); // R8
  AST_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    launch |-> idle); // R10

endmodule

// File: rtl/blkaddr_seq.sv
module blkaddr_seq
  import blkaddr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              hold,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] step,
  input  logic [CNT_W-1:0]  blen,
  input  logic [CNT_W-1:0]  bcnt,
  output logic [ADDR_W-1:0] addr,
  output logic              first_n,
  output logic              blk_end_n,
  output logic              seq_end_n,
  output logic              idle
);
  localparam int EW = CNT_W + 1;

  seq_st_e           st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  pos;
  logic [CNT_W-1:0]  blk;
  logic              fn_q, be_q, se_q;

  logic [EW-1:0] blen_e, bcnt_e, pos_p2, blk_p2;
  logic          in_blk_last, in_seq_last, x_blk_last, x_seq_last;
  logic [ADDR_W-1:0] addr_nx;

  assign blen_e  = {1'b0, blen};
  assign bcnt_e  = {1'b0, bcnt};
  assign pos_p2  = {1'b0, pos} + EW'(2);
  assign blk_p2  = {1'b0, blk} + EW'(2);
  assign addr_nx = addr_q + step;

  // next position stays inside the block
  assign in_blk_last = (pos_p2 >= blen_e);
  assign in_seq_last = in_blk_last && (blk_p2 - EW'(1) >= bcnt_e);
  // next position opens the following block
  assign x_blk_last  = (blen_e <= EW'(1));
  assign x_seq_last  = x_blk_last && (blk_p2 >= bcnt_e);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      addr_q <= '0;
      pos    <= '0;
      blk    <= '0;
      fn_q   <= 1'b1;
      be_q   <= 1'b1;
      se_q   <= 1'b1;
    end else begin
      fn_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (launch) begin
            st     <= S_RUN;
            addr_q <= base;
            pos    <= '0;
            blk    <= '0;
            fn_q   <= 1'b0;
            be_q   <= !(blen_e <= EW'(1));
            se_q   <= !((blen_e <= EW'(1)) && (bcnt_e <= EW'(1)));
          end
        end
        S_RUN: begin
          if (!se_q) begin
            st   <= S_IDLE;
            be_q <= 1'b1;
            se_q <= 1'b1;
          end else if (!be_q) begin
            if (hold) begin
              st   <= S_PAUSE;
              be_q <= 1'b1;
            end else begin
              addr_q <= addr_nx;
              pos    <= '0;
              blk    <= blk + 1'b1;
              be_q   <= !x_blk_last;
              se_q   <= !x_seq_last;
            end
          end else begin
            addr_q <= addr_nx;
            pos    <= pos + 1'b1;
            be_q   <= !in_blk_last;
            se_q   <= !in_seq_last;
          end
        end
        S_PAUSE: begin
          if (!hold) begin
            st     <= S_RUN;
            addr_q <= addr_nx;
            pos    <= '0;
            blk    <= blk + 1'b1;
            be_q   <= !x_blk_last;
            se_q   <= !x_seq_last;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign addr      = addr_q;
  assign first_n   = fn_q;
  assign blk_end_n = be_q;
  assign seq_end_n = se_q;
  assign idle      = (st == S_IDLE);

  AST_FIRST_IS_BASE: assert property (@(posedge clk) disable iff (rst)
    launch |=> (addr == $past(base) && !first_n)); // R4
  AST_STEP_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && blk_end_n) |=> (addr == $past(addr_q + step))); // R5
  AST_END_IN_BLOCK_END: assert property (@(posedge clk) disable iff (rst)
    !seq_end_n |-> !blk_end_n); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !launch) |=> ($stable(addr) && seq_end_n && blk_end_n)); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && !blk_end_n && seq_end_n && hold) |=> ($stable(addr) && blk_end_n)); // R9

endmodule

// File: rtl/blkaddr_gen.sv
module blkaddr_gen #(
  parameter int ADDR_W      = 24,
  parameter int CNT_W       = 16,
  parameter int BUSY_CYCLES = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              go,
  output logic [ADDR_W-1:0] addr,
  output logic              first_n,
  output logic              blk_end_n,
  output logic              seq_end_n,
  output logic              start_out_n,
  output logic              busy_n
);
  logic              wr_ok;
  logic              idle;
  logic              launch;
  logic [ADDR_W-1:0] base, step;
  logic [CNT_W-1:0]  blen, bcnt;

  blkaddr_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .busy_n(busy_n), .wr_ok(wr_ok)
  );

  blkaddr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ok(wr_ok), .wr_sel(wr_sel),
    .wr_data(wr_data), .base(base), .step(step), .blen(blen), .bcnt(bcnt)
  );

  blkaddr_trig u_trig (
    .clk(clk), .rst(rst), .start_n(start_n), .go(go), .wr_ok(wr_ok),
    .idle(idle), .start_out_n(start_out_n), .launch(launch)
  );

  blkaddr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .hold(hold), .base(base),
    .step(step), .blen(blen), .bcnt(bcnt), .addr(addr), .first_n(first_n),
    .blk_end_n(blk_end_n), .seq_end_n(seq_end_n), .idle(idle)
  );

endmodule

// File: tb/blkaddr_gen_bench.sv
module blkaddr_gen_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_n, hold, wr_en, go;
  logic [1:0]  wr_sel;
  logic [23:0] wr_data;
  logic [23:0] addr;
  logic        first_n, blk_end_n, seq_end_n, start_out_n, busy_n;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blkaddr_gen u_blkaddr_gen (
    .clk(clk), .rst(rst), .start_n(start_n), .hold(hold), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .go(go), .addr(addr),
    .first_n(first_n), .blk_end_n(blk_end_n), .seq_end_n(seq_end_n),
    .start_out_n(start_out_n), .busy_n(busy_n)
  );

  typedef struct {
    logic [23:0] a;
    logic        f, b, s;
    int          rq;
  } item_t;

  item_t q[$];
  item_t e;

  function automatic void push(logic [23:0] a, logic f, logic b, logic s, int rq);
    item_t it;
    it.a = a; it.f = f; it.b = b; it.s = s; it.rq = rq;
    q.push_back(it);
  endfunction

  // Expected trace: R4 first, R5 steps, R6 block ends, R7 final + hold, R9 pauses
  function automatic void expect_run(logic [23:0] base, logic [23:0] step,
                                     int blen, int bcnt, int pause);
    logic [23:0] a;
    a = base;
    for (int b = 0; b < bcnt; b++) begin
      for (int p = 0; p < blen; p++) begin
        logic f, bb, s;
        int rq;
        f  = !(b == 0 && p == 0);
        bb = !(p == blen - 1);
        s  = !(p == blen - 1 && b == bcnt - 1);
        rq = !f ? 4 : (!s ? 7 : (!bb ? 6 : 5));
        push(a, f, bb, s, rq);
        if (p == blen - 1 && b == 0 && bcnt > 1)
          for (int k = 0; k < pause; k++) push(a, 1'b1, 1'b1, 1'b1, 9);
        if (!(p == blen - 1 && b == bcnt - 1)) a = a + step;
      end
    end
    push(a, 1'b1, 1'b1, 1'b1, 7);
    push(a, 1'b1, 1'b1, 1'b1, 7);
  endfunction

  // monitor: pops one expected item per cycle, also checks no echo (R8)
  always @(negedge clk) begin
    if (q.size() != 0) begin
      e = q.pop_front();
      checks++;
      if (addr !== e.a || first_n !== e.f || blk_end_n !== e.b ||
          seq_end_n !== e.s || start_out_n !== 1'b1) begin
        failures++;
        $display("FAIL R%0d got a=%h f=%b b=%b s=%b so=%b exp a=%h f=%b b=%b s=%b so=1",
                 e.rq, addr, first_n, blk_end_n, seq_end_n, start_out_n,
                 e.a, e.f, e.b, e.s);
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [23:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ext_start();
    @(negedge clk); start_n = 1'b0;
    @(posedge clk);
    @(negedge clk); start_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int low_cnt;
    rst = 1'b1; start_n = 1'b1; hold = 1'b0; wr_en = 1'b0; go = 1'b0;
    wr_sel = 2'd0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(busy_n === 1'b1, "R1 busy_n in reset", busy_n, 1);
    chk(addr === 24'h0 && first_n && blk_end_n && seq_end_n && start_out_n,
        "R7 reset outputs", addr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_n === 1'b0, "R1 busy one clock after reset", busy_n, 0);
    low_cnt = 0;
    while (busy_n === 1'b0 && low_cnt < 100) begin
      low_cnt++;
      // R2: writes and software start during busy must be ignored
      wr_en = (low_cnt >= 2 && low_cnt <= 4);
      wr_sel = 2'(low_cnt - 2);
      wr_data = 24'h555;
      go = (low_cnt == 6);
      if (start_out_n !== 1'b1) chk(0, "R2 echo during busy", start_out_n, 1);
      @(negedge clk);
    end
    wr_en = 1'b0; go = 1'b0;
    chk(low_cnt == 25, "R1 busy length", low_cnt, 25);
    chk(start_out_n === 1'b1, "R2 no echo after busy go", start_out_n, 1);

    // R2 R3: defaults survive blocked writes (base 0, step 1, len 1, count 1)
    ext_start();
    expect_run(24'h0, 24'h1, 1, 1, 0);
    drain();

    // R5 R6 R7: two blocks of three, step 4
    wr(2'd0, 24'h000100); wr(2'd1, 24'h000004); wr(2'd2, 24'd3); wr(2'd3, 24'd2);
    ext_start();
    expect_run(24'h000100, 24'h4, 3, 2, 0);
    drain();

    // R5 wrap modulo 2^24
    wr(2'd0, 24'hFFFFFE); wr(2'd1, 24'h000003); wr(2'd2, 24'd2); wr(2'd3, 24'd2);
    ext_start();
    expect_run(24'hFFFFFE, 24'h3, 2, 2, 0);
    drain();

    // R3 zero length and count act as one
    wr(2'd0, 24'h00ABCD); wr(2'd2, 24'd0); wr(2'd3, 24'd0);
    ext_start();
    expect_run(24'h00ABCD, 24'h3, 1, 1, 0);
    drain();

    // R8 software start, echo and lockstep timing
    wr(2'd0, 24'h001000); wr(2'd1, 24'h000001); wr(2'd2, 24'd2); wr(2'd3, 24'd1);
    @(negedge clk); go = 1'b1;
    @(posedge clk); #1;
    chk(start_out_n === 1'b0, "R8 echo low", start_out_n, 0);
    chk(first_n === 1'b1, "R8 not started yet", first_n, 1);
    @(negedge clk); go = 1'b0;
    @(posedge clk); #1;
    chk(start_out_n === 1'b1, "R8 echo one clock", start_out_n, 1);
    @(posedge clk); #1;
    expect_run(24'h001000, 24'h1, 2, 1, 0);
    drain();

    // R9 hold: high from before start (no mid-block effect), pause two cycles
    wr(2'd0, 24'h000200); wr(2'd1, 24'h000010); wr(2'd2, 24'd2); wr(2'd3, 24'd2);
    @(negedge clk); hold = 1'b1;
    ext_start();
    expect_run(24'h000200, 24'h10, 2, 2, 2);
    repeat (3) @(posedge clk);
    @(negedge clk); hold = 1'b0;
    drain();

    // R10 start pulse and go during a run are ignored
    wr(2'd0, 24'h003000); wr(2'd1, 24'h000002); wr(2'd2, 24'd4); wr(2'd3, 24'd3);
    ext_start();
    expect_run(24'h003000, 24'h2, 4, 3, 0);
    repeat (2) @(negedge clk);
    start_n = 1'b0;
    @(negedge clk); start_n = 1'b1;
    repeat (2) @(negedge clk);
    go = 1'b1;
    @(negedge clk); go = 1'b0;
    drain();
    chk(addr === 24'h003016, "R10 final address unchanged", addr, 24'h003016);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule